// File: doc/BRIEF.md
# Write Permission Guard and Status Byte

This block decides whether a programming request to a small serial nonvolatile byte array may go ahead. It holds two pieces of state. The first is a write-enable latch, which software sets and clears with dedicated commands. The second is a two-bit protection level that fences off a nested upper part of the address space. The command decoder presents decoded strobes: set-enable, clear-enable, status-write with its data byte, and data-write with its byte address. The guard answers each request in the same cycle with a grant or a deny. It also always presents the status byte that a status-read command shifts out.

The programming timer reports activity through `busy` and signals completion with a one-cycle `cycle_done` pulse. Completion returns the latch to the disabled state. While `busy` is high, the block accepts no command and the status byte reads as all ones. Only the ready bit carries meaning in that state. The protection level stands in for nonvolatile bits and takes the value `PROT_INIT` at power-up reset.

Top module: `wp_status_guard`

## Requirements
- R1: After reset the enable latch is clear, the protection level equals `PROT_INIT` (default 0), and the idle status byte reads 0xF0.
- R2: When `busy` is low, the status byte is {4'b1111, level[1], level[0], latch, 1'b0}. Bit 3 and bit 2 hold the level, bit 1 the latch and bit 0 the ready flag (0 = ready).
- R3: When `busy` is high, the status byte is 0xFF.
- R4: `cmd_set_en` sets the latch on the next edge. `cmd_clr_en` clears it. When both are strobed together, the latch is cleared.
- R5: A `cycle_done` pulse clears the latch on the next edge, whatever else is strobed.
- R6: `data_grant` is high only when `cmd_data_wr`, `wp_high` and the latch are all high, `busy` is low, and the address lies outside the protected range. `data_deny` is high exactly when a data write is requested and not granted.
- R7: Protected ranges by level: 0 protects nothing, 1 protects 0x180–0x1FF, 2 protects 0x100–0x1FF, 3 protects 0x000–0x1FF.
- R8: `status_grant` is high only when `cmd_status_wr`, `wp_high` and the latch are all high and `busy` is low. `status_deny` covers every other status-write request. A granted write loads the level from data bits 3:2 on the next edge and ignores the other data bits.
- R9: A denied request changes neither the level nor the latch.
- R10: While `busy` is high, `cmd_set_en` and `cmd_clr_en` have no effect on the latch, which is seen once `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| wp_high | input | 1 | Hardware write-permit level, high allows programming |
| busy | input | 1 | Programming cycle in progress |
| cycle_done | input | 1 | One-cycle pulse when a programming cycle ends |
| cmd_set_en | input | 1 | Set-enable command strobe |
| cmd_clr_en | input | 1 | Clear-enable command strobe |
| cmd_status_wr | input | 1 | Status-write request strobe |
| status_wdata | input | 8 | Data byte of the status write |
| cmd_data_wr | input | 1 | Data-write request strobe |
| data_addr | input | ADDR_W | Byte address of the data write |
| data_grant | output | 1 | Data write allowed |
| data_deny | output | 1 | Data write refused |
| status_grant | output | 1 | Status write allowed |
| status_deny | output | 1 | Status write refused |
| status_byte | output | 8 | Byte returned by a status read |

## Verification
The assertions assume the decoder issues at most one of status-write and data-write per cycle. The one exception is the set/clear pair, which may arrive together. The assertions also assume that `cycle_done` arrives while `busy` is low or is falling. The bench drives single strobes in its random phase and pairs set with clear only in a directed step. It pulses `cycle_done` only on cycles where `busy` is low. A behavioural model in the bench compares every output on every cycle, across all four levels and both `wp_high` values.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

    typedef logic [1:0] prot_level_t;

    typedef struct packed {
        logic       set_en;
        logic       clr_en;
        logic       done;
        logic       busy;
    } latch_ctl_t;

    localparam logic [7:0] STATUS_BUSY = 8'hFF;
    localparam logic [3:0] STATUS_PAD  = 4'hF;

    // Nested upper ranges: quarter, half, whole array.
    function automatic logic addr_locked(input prot_level_t lvl, input logic [1:0] top2);
        case (lvl)
            2'd0:    return 1'b0;
            2'd1:    return top2 == 2'b11;
            2'd2:    return top2[1];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/wpg_enable_latch.sv
module wpg_enable_latch
    import wpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  latch_ctl_t ctl,
    output logic       enabled
);
    always_ff @(posedge clk) begin
        if (rst)
            enabled <= 1'b0;
        else if (ctl.done || (ctl.clr_en && !ctl.busy))
            enabled <= 1'b0;
        else if (ctl.set_en && !ctl.busy)
            enabled <= 1'b1;
    end
endmodule

// File: rtl/wpg_protect_reg.sv
module wpg_protect_reg
    import wpg_pkg::*;
#(
    parameter prot_level_t INIT = 2'd0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  prot_level_t next_level,
    output prot_level_t level
);
    always_ff @(posedge clk) begin
        if (rst)
            level <= INIT;
        else if (load)
            level <= next_level;
    end
endmodule

// File: rtl/wpg_grant.sv
module wpg_grant
    import wpg_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              wp_high,
    input  logic              busy,
    input  logic              enabled,
    input  prot_level_t       level,
    input  logic              data_req,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic              status_req,
    output logic              data_ok,
    output logic              data_no,
    output logic              status_ok,
    output logic              status_no
);
    localparam int TOP = ADDR_W - 1;

    logic permitted;
    logic locked;

    always_comb begin
        permitted = wp_high && enabled && !busy;
        locked    = addr_locked(level, data_addr[TOP -: 2]);
        data_ok   = data_req && permitted && !locked;
        data_no   = data_req && !data_ok;
        status_ok = status_req && permitted;
        status_no = status_req && !status_ok;
    end
endmodule

// File: rtl/wp_status_guard.sv
module wp_status_guard
    import wpg_pkg::*;
#(
    parameter int          ADDR_W    = 9,
    parameter prot_level_t PROT_INIT = 2'd0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_high,
    input  logic              busy,
    input  logic              cycle_done,
    input  logic              cmd_set_en,
    input  logic              cmd_clr_en,
    input  logic              cmd_status_wr,
    input  logic [7:0]        status_wdata,
    input  logic              cmd_data_wr,
    input  logic [ADDR_W-1:0] data_addr,
    output logic              data_grant,
    output logic              data_deny,
    output logic              status_grant,
    output logic              status_deny,
    output logic [7:0]        status_byte
);
    latch_ctl_t  ctl;
    logic        enabled;
    prot_level_t level;

    assign ctl = '{set_en: cmd_set_en, clr_en: cmd_clr_en, done: cycle_done, busy: busy};

    wpg_enable_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .enabled (enabled)
    );

    wpg_protect_reg #(.INIT(PROT_INIT)) u_level (
        .clk        (clk),
        .rst        (rst),
        .load       (status_grant),
        .next_level (status_wdata[3:2]),
        .level      (level)
    );

    wpg_grant #(.ADDR_W(ADDR_W)) u_grant (
        .wp_high    (wp_high),
        .busy       (busy),
        .enabled    (enabled),
        .level      (level),
        .data_req   (cmd_data_wr),
        .data_addr  (data_addr),
        .status_req (cmd_status_wr),
        .data_ok    (data_grant),
        .data_no    (data_deny),
        .status_ok  (status_grant),
        .status_no  (status_deny)
    );

    always_comb begin
        if (busy)
            status_byte = STATUS_BUSY;
        else
            status_byte = {STATUS_PAD, level, enabled, 1'b0};
    end
endmodule

// File: rtl/wpg_checker.sv
module wpg_checker (
    input logic       clk,
    input logic       rst,
    input logic       wp_high,
    input logic       busy,
    input logic       cycle_done,
    input logic       cmd_set_en,
    input logic       cmd_clr_en,
    input logic [7:0] status_wdata,
    input logic       data_grant,
    input logic       data_deny,
    input logic       status_grant,
    input logic       status_deny,
    input logic [7:0] status_byte
);
    a_r3_busy_all_ones: assert property (@(posedge clk) disable iff (rst)
        busy |-> status_byte == 8'hFF);

    a_r2_idle_layout: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (status_byte[7:4] == 4'hF && !status_byte[0]));

    a_r6_wp_blocks: assert property (@(posedge clk) disable iff (rst)
        !wp_high |-> !(data_grant || status_grant));

    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(data_grant && data_deny) && !(status_grant && status_deny));

    a_r4_set_latch: assert property (@(posedge clk) disable iff (rst)
        (cmd_set_en && !cmd_clr_en && !cycle_done && !busy) |=> (busy || status_byte[1]));

    a_r5_done_clears: assert property (@(posedge clk) disable iff (rst)
        cycle_done |=> (busy || !status_byte[1]));

    a_r8_level_load: assert property (@(posedge clk) disable iff (rst)
        status_grant |=> (busy || status_byte[3:2] == $past(status_wdata[3:2])));

    a_r9_deny_keeps_level: assert property (@(posedge clk) disable iff (rst)
        (status_deny && !busy) |=> (busy || status_byte[3:2] == $past(status_byte[3:2])));
endmodule

bind wp_status_guard wpg_checker u_wpg_checker (
    .clk          (clk),
    .rst          (rst),
    .wp_high      (wp_high),
    .busy         (busy),
    .cycle_done   (cycle_done),
    .cmd_set_en   (cmd_set_en),
    .cmd_clr_en   (cmd_clr_en),
    .status_wdata (status_wdata),
    .data_grant   (data_grant),
    .data_deny    (data_deny),
    .status_grant (status_grant),
    .status_deny  (status_deny),
    .status_byte  (status_byte)
);

// File: tb/test_wp_status_guard.sv
`timescale 1ns/100ps
module test_wp_status_guard;
    logic       clk = 1'b0;
    logic       rst;
    logic       wp_high, busy, cycle_done, cmd_set_en, cmd_clr_en;
    logic       cmd_status_wr, cmd_data_wr;
    logic [7:0] status_wdata;
    logic [8:0] data_addr;
    logic       data_grant, data_deny, status_grant, status_deny;
    logic [7:0] status_byte;

    int checks = 0;
    int failures = 0;

    // behavioural reference state
    int ref_wel = 0;
    int ref_lvl = 0;

    always #2 clk = ~clk;

    wp_status_guard i_wp_status_guard (
        .clk(clk), .rst(rst), .wp_high(wp_high), .busy(busy), .cycle_done(cycle_done),
        .cmd_set_en(cmd_set_en), .cmd_clr_en(cmd_clr_en), .cmd_status_wr(cmd_status_wr),
        .status_wdata(status_wdata), .cmd_data_wr(cmd_data_wr), .data_addr(data_addr),
        .data_grant(data_grant), .data_deny(data_deny), .status_grant(status_grant),
        .status_deny(status_deny), .status_byte(status_byte)
    );

    function automatic bit fenced(int lvl, int addr);
        if (lvl == 0) return 0;
        if (lvl == 1) return addr >= 384;
        if (lvl == 2) return addr >= 256;
        return 1;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle: drive after negedge, compare, then advance model.
    task automatic cyc(string tag, bit wp, bit bz, bit dn, bit se, bit ce,
                       bit sw, int wd, bit dw, int ad);
        bit ok;
        bit gd;
        bit gs;
        int exp_st;
        @(negedge clk);
        wp_high = wp; busy = bz; cycle_done = dn; cmd_set_en = se; cmd_clr_en = ce;
        cmd_status_wr = sw; status_wdata = wd[7:0]; cmd_data_wr = dw; data_addr = ad[8:0];
        #1;
        ok = wp && ref_wel != 0 && !bz;
        gd = dw && ok && !fenced(ref_lvl, ad);
        gs = sw && ok;
        exp_st = bz ? 255 : (240 + ref_lvl * 4 + ref_wel * 2);
        check({tag, " status"}, status_byte, exp_st);
        check({tag, " dgrant"}, {data_grant, data_deny}, {gd, dw && !gd});
        check({tag, " sgrant"}, {status_grant, status_deny}, {gs, sw && !gs});
        if (dn || (ce && !bz)) ref_wel = 0;
        else if (se && !bz) ref_wel = 1;
        if (gs) ref_lvl = (wd >> 2) & 3;
    endtask

    task automatic idle(string tag);
        cyc(tag, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1;
        wp_high = 0; busy = 0; cycle_done = 0; cmd_set_en = 0; cmd_clr_en = 0;
        cmd_status_wr = 0; status_wdata = 0; cmd_data_wr = 0; data_addr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle("R1 reset");
        cyc("R6 latch clear", 1, 0, 0, 0, 0, 0, 0, 1, 511);
        cyc("R4 set", 1, 0, 0, 1, 0, 0, 0, 0, 0);
        idle("R2 layout");
        cyc("R6 lvl0 top", 1, 0, 0, 0, 0, 0, 0, 1, 511);
        cyc("R3 busy", 1, 1, 0, 0, 0, 0, 0, 0, 0);
        cyc("R10 clr ignored", 1, 1, 0, 0, 1, 0, 0, 0, 0);
        cyc("R3 busy write", 1, 1, 0, 0, 0, 0, 0, 1, 5);
        cyc("R5 done", 1, 0, 1, 0, 0, 0, 0, 0, 0);
        idle("R5 cleared");
        cyc("R4 set", 1, 0, 0, 1, 0, 0, 0, 0, 0);
        cyc("R8 wrsr 0xF7", 1, 0, 0, 0, 0, 1, 8'hF7, 0, 0);
        idle("R8 level1");
        cyc("R7 0x180", 1, 0, 0, 0, 0, 0, 0, 1, 384);
        cyc("R7 0x17F", 1, 0, 0, 0, 0, 0, 0, 1, 383);
        cyc("R8 wrsr lvl2", 1, 0, 0, 0, 0, 1, 8'h08, 0, 0);
        cyc("R7 0x100", 1, 0, 0, 0, 0, 0, 0, 1, 256);
        cyc("R7 0x0FF", 1, 0, 0, 0, 0, 0, 0, 1, 255);
        cyc("R8 wrsr lvl3", 1, 0, 0, 0, 0, 1, 8'h0C, 0, 0);
        cyc("R7 0x000", 1, 0, 0, 0, 0, 0, 0, 1, 0);
        cyc("R6 wp low", 0, 0, 0, 0, 0, 0, 0, 1, 0);
        cyc("R9 wp low wrsr", 0, 0, 0, 0, 0, 1, 8'h00, 0, 0);
        idle("R9 kept");
        cyc("R4 both", 1, 0, 0, 1, 1, 0, 0, 0, 0);
        cyc("R9 latch off wrsr", 1, 0, 0, 0, 0, 1, 8'h00, 0, 0);
        idle("R9 kept2");
        cyc("R10 set busy", 1, 1, 0, 1, 0, 0, 0, 0, 0);
        idle("R10 after busy");
        for (int i = 0; i < 400; i++) begin
            int k = $urandom_range(0, 7);
            bit bz = ($urandom_range(0, 3) == 0);
            bit wp = ($urandom_range(0, 4) != 0);
            cyc("R6 random", wp, bz, (k == 0) && !bz, k == 1 || k == 2, k == 3,
                k == 4, $urandom_range(0, 255), k >= 5, $urandom_range(0, 511));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule